// File: doc/BRIEF.md
# Dual Eight-Stage Serial Shifter with Selectable Input

This block holds two independent serial-in shift registers of eight stages each. Each register (a "lane") has a private clock pin, and there is also a shared clock pin that drives both lanes. A lane advances by one stage each time the OR of its private pin and the shared pin goes from low to high. While either pin is held high, activity on the other pin is masked, so a high level on one pin acts as a shift inhibit.

The serial bit that enters a lane comes from one of two data pins, chosen by that lane's select pin. Each lane presents its oldest stage on a true output and on a complemented output. One active-low reset clears all sixteen stages at once.

The clock pins are slow strobes, not real clocks. Together with the data and select pins, they are sampled into the fast system clock domain through a two-flop synchronizer. Edges are then found synchronously, so the design has no gated or derived clocks.

Top module: `twin_shift_reg`

## Requirements
- R1: Each lane holds DEPTH (default 8) stages. Stage 0 is the entry stage and stage DEPTH-1 is the stage presented at the output.
- R2: A lane shifts exactly once when the OR of its private clock pin and the shared clock pin goes from 0 to 1. This applies when either pin rises alone and when both rise together.
- R3: On each shift, every stage i takes the former value of stage i-1, and stage 0 takes the serial bit.
- R4: While either clock pin of a lane is high, transitions of the other pin cause no shift. Without a rising OR, a lane's stages keep their values.
- R5: The serial bit is `din_a` when `pick_b` is 0 and `din_b` when `pick_b` is 1. It is taken at the same sample as the rising clock. Data or select changes while the OR stays high have no effect.
- R6: Driving `rst_n` low clears every stage of both lanes at once, without waiting for a clock edge. While reset is held and after its release, `tail` reads 0 and `tail_n` reads 1.
- R7: A bit that enters a lane first reaches `tail` on the eighth shift and not earlier.
- R8: `tail_n` is always the complement of `tail` for each lane.
- R9: The shared pin shifts both lanes. A private pin shifts only its own lane.
- R10: After a clock pin rises, the output reflects the shift on the third rising edge of `clk`: two synchronizer stages plus the stage register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Active-low master reset; asserts asynchronously and releases synchronously |
| shared_tck | input | 1 | Clock pin common to both lanes |
| lane_tck | input | LANES | Private clock pin of each lane |
| din_a | input | LANES | Serial data choice used when the select is 0 |
| din_b | input | LANES | Serial data choice used when the select is 1 |
| pick_b | input | LANES | Per-lane data select |
| tail | output | LANES | Last stage of each lane |
| tail_n | output | LANES | Complement of the last stage of each lane |

## Verification
Only the last stage of each lane is visible, so an error in an inner stage stays hidden until it has moved through the rest of the lane. That takes up to seven more shifts. A single spurious or missing shift, however, offsets every later bit by one position. The random phase therefore drives long bit streams and compares `tail` after every pin change, and it reports such an offset within a few strobes. Directed cases pin down the exact three-cycle latency, the eighth-shift arrival, the asynchronous clear and the inhibit behaviour.

// File: rtl/twin_shift_pkg.sv
package twin_shift_pkg;
  localparam int unsigned DEF_LANES = 2;
  localparam int unsigned DEF_DEPTH = 8;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/tss_sync_bank.sv
module tss_sync_bank #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = din;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tss_rise_detect.sv
module tss_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic strobe
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign strobe = level & ~prev_q;

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/tss_lane.sv
module tss_lane #(
  parameter int unsigned DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic bit_a,
  input  logic bit_b,
  input  logic pick,
  output logic tail,
  output logic tail_n
);
  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;
  logic             ser_bit;

  assign ser_bit = pick ? bit_b : bit_a;

  always_comb begin
    stage_d = stage_q;
    if (shift_en) stage_d = {stage_q[DEPTH-2:0], ser_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign tail   = stage_q[DEPTH-1];
  assign tail_n = ~stage_q[DEPTH-1];

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stage_q));
  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> stage_q[DEPTH-1:1] == $past(stage_q[DEPTH-2:0]));
  // R5
  entry_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> stage_q[0] == ($past(pick) ? $past(bit_b) : $past(bit_a)));
endmodule

// File: rtl/twin_shift_reg.sv
module twin_shift_reg
  import twin_shift_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned DEPTH = DEF_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shared_tck,
  input  logic [LANES-1:0] lane_tck,
  input  logic [LANES-1:0] din_a,
  input  logic [LANES-1:0] din_b,
  input  logic [LANES-1:0] pick_b,
  output logic [LANES-1:0] tail,
  output logic [LANES-1:0] tail_n
);
  localparam int unsigned PIN_W = 1 + 4 * LANES;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [PIN_W-1:0] pin_raw;
  logic [PIN_W-1:0] pin_s;

  assign pin_raw = {pick_b, din_b, din_a, lane_tck, shared_tck};

  tss_sync_bank #(.W(PIN_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (pin_raw),
    .dout  (pin_s)
  );

  logic             shared_s;
  logic [LANES-1:0] tck_s, a_s, b_s, pick_s, or_lvl, shift_en;

  assign shared_s = pin_s[0];
  assign tck_s    = pin_s[LANES:1];
  assign a_s      = pin_s[2*LANES:LANES+1];
  assign b_s      = pin_s[3*LANES:2*LANES+1];
  assign pick_s   = pin_s[4*LANES:3*LANES+1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign or_lvl[l] = tck_s[l] | shared_s;

    tss_rise_detect u_rise (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .level  (or_lvl[l]),
      .strobe (shift_en[l])
    );

    tss_lane #(.DEPTH(DEPTH)) u_lane (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .shift_en (shift_en[l]),
      .bit_a    (a_s[l]),
      .bit_b    (b_s[l]),
      .pick     (pick_s[l]),
      .tail     (tail[l]),
      .tail_n   (tail_n[l])
    );

    // R9
    shared_reach_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      ($rose(shared_s) && !$past(tck_s[l])) |-> shift_en[l]);
  end
endmodule

// File: tb/tb_twin_shift_reg.sv
module tb_twin_shift_reg;
  logic       clk;
  logic       rst_n;
  logic       shared_tck;
  logic [1:0] lane_tck, din_a, din_b, pick_b;
  logic [1:0] tail, tail_n;

  twin_shift_reg dut (
    .clk(clk), .rst_n(rst_n), .shared_tck(shared_tck), .lane_tck(lane_tck),
    .din_a(din_a), .din_b(din_b), .pick_b(pick_b), .tail(tail), .tail_n(tail_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [7:0] model_q [2];
  logic       or_prev [2];

  function automatic logic sel_bit(input logic s, input logic a, input logic b);
    return s ? b : a;
  endfunction

  task automatic check(input logic cond, input string req, input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_lanes(input string req);
    for (int l = 0; l < 2; l++) begin
      check(tail[l] == model_q[l][7], req, tail[l], model_q[l][7]);
      check(tail_n[l] == ~model_q[l][7], {req, " R8"}, tail_n[l], ~model_q[l][7]);
    end
  endtask

  task automatic drive_pins(input logic sh, input logic [1:0] lt,
                            input logic [1:0] a, input logic [1:0] b, input logic [1:0] s);
    shared_tck = sh; lane_tck = lt; din_a = a; din_b = b; pick_b = s;
    for (int l = 0; l < 2; l++) begin
      logic or_new;
      or_new = sh | lt[l];
      if (or_new && !or_prev[l])
        model_q[l] = {model_q[l][6:0], sel_bit(s[l], a[l], b[l])};
      or_prev[l] = or_new;
    end
  endtask

  task automatic step(input logic sh, input logic [1:0] lt,
                      input logic [1:0] a, input logic [1:0] b, input logic [1:0] s,
                      input string req);
    @(negedge clk);
    drive_pins(sh, lt, a, b, s);
    repeat (4) @(negedge clk);
    check_lanes(req);
  endtask

  task automatic pulse(input logic sh, input logic [1:0] lt, input logic [1:0] a,
                       input logic [1:0] b, input logic [1:0] s, input string req);
    step(sh, lt, a, b, s, req);
    step(1'b0, 2'b00, a, b, s, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    drive_pins(1'b0, 2'b00, 2'b00, 2'b00, 2'b00);
    rst_n = 1'b0;
    #1;
    check(tail == 2'b00, "R6 async clear", tail, 0);
    check(tail_n == 2'b11, "R6 async clear", tail_n, 3);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int l = 0; l < 2; l++) begin model_q[l] = '0; or_prev[l] = 1'b0; end
    repeat (5) @(negedge clk);
    check_lanes("R6 after release");
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; shared_tck = 0; lane_tck = 0; din_a = 0; din_b = 0; pick_b = 0;
    for (int l = 0; l < 2; l++) begin model_q[l] = '0; or_prev[l] = 1'b0; end
    repeat (4) @(negedge clk);
    check(tail == 2'b00, "R6 reset state", tail, 0);
    check(tail_n == 2'b11, "R6 reset state", tail_n, 3);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7: one marker bit on lane 0 through din_a, lane 1 through din_b
    pulse(1'b0, 2'b11, 2'b01, 2'b10, 2'b10, "R7 R5 entry");
    for (int k = 0; k < 6; k++) pulse(1'b0, 2'b11, 2'b00, 2'b00, 2'b10, "R7 early");
    check(tail == 2'b00, "R7 not before eighth", tail, 0);

    // R10: eighth rise observed on the third clk edge
    @(negedge clk);
    drive_pins(1'b0, 2'b11, 2'b00, 2'b00, 2'b00);
    @(posedge clk); @(posedge clk); #1;
    check(tail == 2'b00, "R10 no change after two edges", tail, 0);
    @(posedge clk); #1;
    check(tail == 2'b11, "R10 R7 change on third edge", tail, 3);
    repeat (4) @(negedge clk);
    step(1'b0, 2'b00, 2'b00, 2'b00, 2'b00, "R2");

    // R9: private clock shifts one lane only; shared shifts both
    pulse(1'b0, 2'b01, 2'b11, 2'b11, 2'b00, "R9 private");
    pulse(1'b1, 2'b00, 2'b11, 2'b11, 2'b00, "R9 shared");
    // R2: both pins rising together count once
    pulse(1'b1, 2'b11, 2'b01, 2'b10, 2'b00, "R2 joint rise");

    // R4: shared held high, private toggles and data changes do nothing
    step(1'b1, 2'b00, 2'b11, 2'b11, 2'b00, "R2");
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 2'b11, 2'(k), 2'(~k), 2'(k+1), "R4 inhibit");
      step(1'b1, 2'b00, 2'(~k), 2'(k), 2'(k), "R4 inhibit");
    end
    step(1'b0, 2'b00, 2'b00, 2'b00, 2'b00, "R4");
    // R5: data changed while clock high is ignored
    step(1'b0, 2'b11, 2'b11, 2'b00, 2'b00, "R5");
    step(1'b0, 2'b11, 2'b00, 2'b11, 2'b00, "R5 late data");
    step(1'b0, 2'b00, 2'b00, 2'b00, 2'b00, "R5");
    for (int k = 0; k < 8; k++) pulse(1'b0, 2'b11, 2'(k), 2'(k >> 1), 2'(k >> 2), "R3 R1 flush");

    do_reset();

    for (int n = 0; n < 400; n++) begin
      logic sh;
      sh = ($urandom % 4) == 0;
      step(sh, 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), "R2 R3 R5 random");
    end

    for (int k = 0; k < 8; k++) pulse(1'b1, 2'b00, 2'b11, 2'b11, 2'b00, "R3 fill");
    do_reset();

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule